// File: doc/BRIEF.md
# UART Interrupt Request and Line Control

This block sits next to a UART core and turns the core's status into three interrupt request lines: transmit, receive and receive-error. The transmit and receive lines can each work in pulse or level style. In pulse style a request lasts one clock cycle and marks the moment a condition becomes true. In level style the request stays high for as long as the condition holds. Which status signal counts as the condition depends on whether the FIFOs are enabled. A receive timeout from the core counts as a receive request, but only when timeouts are enabled and the FIFOs are on.

The block also owns the serial line. A one-cycle command starts a break. During a break the outgoing line is forced low for exactly one character frame, counted on the transmitter's bit-tick enable. The break then ends by itself. A loopback switch feeds the outgoing serial stream back into the receiver and parks the external transmit pin at idle high. A break started during loopback is therefore seen only on the internal receive input.

Every output is registered. A change at the inputs shows up at the outputs one clock later.

Top module: `uart_irq_line_ctl`

## Requirements
- R1: While `rst` is high, at the next clock edge `irq_tx`, `irq_rx`, `irq_err` and `brk_active` go to 0, and `pin_txd` and `core_rxd` go to 1.
- R2: With `cfg_tx_level`=0 (pulse), `irq_tx` is high for exactly one cycle, one clock after the selected transmit condition rises. It stays low while the condition is held, and pulses again only after the condition has fallen and risen again.
- R3: With `cfg_tx_level`=1 (level), `irq_tx` equals the selected transmit condition delayed by one clock.
- R4: The transmit condition is `tx_empty` when `cfg_fifo_en`=0 and `tx_fifo_trig` when `cfg_fifo_en`=1. The receive condition is `rx_data_avail` when `cfg_fifo_en`=0 and `rx_fifo_trig` when `cfg_fifo_en`=1. The status signal that is not selected has no effect.
- R5: `irq_rx` follows the receive condition with the same pulse (`cfg_rx_level`=0) or level (`cfg_rx_level`=1) behaviour as in R2 and R3.
- R6: `rx_timeout` joins the receive condition, and so appears on `irq_rx`, only when both `cfg_timeout_en` and `cfg_fifo_en` are 1. Otherwise it has no effect.
- R7: With `cfg_err_en`=1, any bit of `rx_err` (bit 0 break, bit 1 framing, bit 2 parity, bit 3 overrun) drives `irq_err` high one clock later. With `cfg_err_en`=0, `irq_err` stays 0.
- R8: A one-cycle `brk_set` raises `brk_active` at the next edge. One clock later `pin_txd` goes to 0 (outside loopback). `brk_active` stays high until the frame-length-th `bit_tick` seen after it rose, and it clears at that tick. A `brk_set` during an active break is ignored, and a `bit_tick` in the same cycle as `brk_set` is not counted.
- R9: The frame length in bit ticks is 1 + (5 + `cfg_data_bits`) + `cfg_parity_en` + (2 if `cfg_two_stop` else 1). This gives 7 to 12 ticks.
- R10: With `cfg_loopback`=1, `pin_txd` is 1, `core_rxd` follows `ser_tx` one clock later, and `pin_rxd` has no effect. With `cfg_loopback`=0, `pin_txd` follows `ser_tx` and `core_rxd` follows `pin_rxd`, each one clock later.
- R11: A break during loopback drives `core_rxd` to 0 while `pin_txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tx_level | input | 1 | Transmit request style: 0 pulse, 1 level |
| cfg_rx_level | input | 1 | Receive request style: 0 pulse, 1 level |
| cfg_timeout_en | input | 1 | Allow receive timeout requests |
| cfg_err_en | input | 1 | Allow error requests |
| cfg_loopback | input | 1 | Internal loopback |
| cfg_fifo_en | input | 1 | FIFO mode |
| cfg_parity_en | input | 1 | Parity bit in frame |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_data_bits | input | 2 | Data bits minus 5 |
| brk_set | input | 1 | Start-break command (one cycle) |
| bit_tick | input | 1 | Transmit bit-period enable |
| tx_empty | input | 1 | Transmit holding buffer empty |
| tx_fifo_trig | input | 1 | Transmit FIFO at trigger level |
| rx_data_avail | input | 1 | Receive holding buffer has data |
| rx_fifo_trig | input | 1 | Receive FIFO at trigger level |
| rx_timeout | input | 1 | Receive timeout from core |
| rx_err | input | 4 | Break, framing, parity, overrun flags |
| ser_tx | input | 1 | Serializer output |
| pin_rxd | input | 1 | External receive pin |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| brk_active | output | 1 | Break in progress |
| pin_txd | output | 1 | External transmit pin |
| core_rxd | output | 1 | Deserializer input |

## Verification
Two pairs of events can fall in the same cycle, and both are driven on purpose. In the first, a break start and a bit tick arrive together; the bench checks that the break still lasts a full frame length of later ticks. In the second, a break runs while loopback is on; the bench expects the low level on `core_rxd` and an idle-high `pin_txd` for the whole frame. Frame lengths are checked for several data, parity and stop settings. One case also re-issues the break command partway through a break, and the bench checks that this does not lengthen the frame.

// File: rtl/uart_ilc_pkg.sv
package uart_ilc_pkg;
  typedef enum logic {
    REQ_PULSE = 1'b0,
    REQ_LEVEL = 1'b1
  } req_mode_e;

  localparam int unsigned CH_TX  = 0;
  localparam int unsigned CH_RX  = 1;
  localparam int unsigned CH_ERR = 2;
  localparam int unsigned N_CH   = 3;
endpackage

// File: rtl/ilc_req_gen.sv
module ilc_req_gen
  import uart_ilc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  req_mode_e mode,
  input  logic      cond,
  output logic      req
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      cond_q <= cond;
      req    <= (mode == REQ_LEVEL) ? cond : (cond & ~cond_q);
    end
  end
endmodule

// File: rtl/ilc_break_timer.sv
module ilc_break_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_set,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] frame_len,
  output logic             brk_active
);
  logic [CNT_W-1:0] tick_cnt;
  logic             last_tick;

  assign last_tick = bit_tick && ((tick_cnt + 1'b1) == frame_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_active <= 1'b0;
      tick_cnt   <= '0;
    end else if (!brk_active) begin
      tick_cnt <= '0;
      if (brk_set) brk_active <= 1'b1;
    end else if (last_tick) begin
      brk_active <= 1'b0;
      tick_cnt   <= '0;
    end else if (bit_tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ilc_line_route.sv
module ilc_line_route (
  input  logic clk,
  input  logic rst,
  input  logic loopback,
  input  logic brk_active,
  input  logic ser_tx,
  input  logic pin_rxd,
  output logic pin_txd,
  output logic core_rxd
);
  logic line_out;

  assign line_out = ser_tx & ~brk_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_txd  <= 1'b1;
      core_rxd <= 1'b1;
    end else begin
      pin_txd  <= loopback ? 1'b1 : line_out;
      core_rxd <= loopback ? line_out : pin_rxd;
    end
  end
endmodule

// File: rtl/uart_irq_line_ctl.sv
module uart_irq_line_ctl
  import uart_ilc_pkg::*;
#(
  parameter int unsigned DATA_MIN = 5,
  parameter int unsigned DBIT_W   = 2,
  parameter int unsigned ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tx_level,
  input  logic              cfg_rx_level,
  input  logic              cfg_timeout_en,
  input  logic              cfg_err_en,
  input  logic              cfg_loopback,
  input  logic              cfg_fifo_en,
  input  logic              cfg_parity_en,
  input  logic              cfg_two_stop,
  input  logic [DBIT_W-1:0] cfg_data_bits,
  input  logic              brk_set,
  input  logic              bit_tick,
  input  logic              tx_empty,
  input  logic              tx_fifo_trig,
  input  logic              rx_data_avail,
  input  logic              rx_fifo_trig,
  input  logic              rx_timeout,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              ser_tx,
  input  logic              pin_rxd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              brk_active,
  output logic              pin_txd,
  output logic              core_rxd
);
  localparam int unsigned MAX_FRAME = 1 + DATA_MIN + (2**DBIT_W - 1) + 1 + 2;
  localparam int unsigned CNT_W     = $clog2(MAX_FRAME + 1);

  logic [N_CH-1:0] ch_cond;
  logic [N_CH-1:0] ch_req;
  req_mode_e       ch_mode [N_CH];
  logic [CNT_W-1:0] frame_len;
  logic            to_qual;

  assign to_qual = cfg_timeout_en & cfg_fifo_en & rx_timeout;

  assign ch_cond[CH_TX]  = cfg_fifo_en ? tx_fifo_trig : tx_empty;
  assign ch_cond[CH_RX]  = (cfg_fifo_en ? rx_fifo_trig : rx_data_avail) | to_qual;
  assign ch_cond[CH_ERR] = cfg_err_en & (|rx_err);

  assign ch_mode[CH_TX]  = req_mode_e'(cfg_tx_level);
  assign ch_mode[CH_RX]  = req_mode_e'(cfg_rx_level);
  assign ch_mode[CH_ERR] = REQ_LEVEL;

  for (genvar g = 0; g < N_CH; g++) begin : g_req
    ilc_req_gen u_req (
      .clk  (clk),
      .rst  (rst),
      .mode (ch_mode[g]),
      .cond (ch_cond[g]),
      .req  (ch_req[g])
    );
  end

  assign irq_tx  = ch_req[CH_TX];
  assign irq_rx  = ch_req[CH_RX];
  assign irq_err = ch_req[CH_ERR];

  assign frame_len = CNT_W'(1 + DATA_MIN + int'(cfg_data_bits) + int'(cfg_parity_en)
                            + (cfg_two_stop ? 2 : 1));

  ilc_break_timer #(.CNT_W(CNT_W)) u_brk (
    .clk        (clk),
    .rst        (rst),
    .brk_set    (brk_set),
    .bit_tick   (bit_tick),
    .frame_len  (frame_len),
    .brk_active (brk_active)
  );

  ilc_line_route u_route (
    .clk        (clk),
    .rst        (rst),
    .loopback   (cfg_loopback),
    .brk_active (brk_active),
    .ser_tx     (ser_tx),
    .pin_rxd    (pin_rxd),
    .pin_txd    (pin_txd),
    .core_rxd   (core_rxd)
  );
endmodule

// File: rtl/uart_irq_line_ctl_chk.sv
module uart_irq_line_ctl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_tx_level,
  input logic cfg_rx_level,
  input logic cfg_err_en,
  input logic cfg_loopback,
  input logic cfg_fifo_en,
  input logic rx_data_avail,
  input logic bit_tick,
  input logic irq_tx,
  input logic irq_rx,
  input logic irq_err,
  input logic brk_active,
  input logic pin_txd
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!irq_tx && !irq_rx && !irq_err && !brk_active && pin_txd));

  p_tx_pulse_width_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_tx_level && irq_tx) |=> !irq_tx);

  p_rx_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rx_level && irq_rx) |=> !irq_rx);

  p_timeout_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo_en && !rx_data_avail) |=> !irq_rx);

  p_err_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_err_en |=> !irq_err);

  p_break_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (brk_active && !bit_tick) |=> brk_active);

  p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
    (brk_active && !cfg_loopback) |=> !pin_txd);

  p_loop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_loopback |=> pin_txd);
endmodule

bind uart_irq_line_ctl uart_irq_line_ctl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_tx_level  (cfg_tx_level),
  .cfg_rx_level  (cfg_rx_level),
  .cfg_err_en    (cfg_err_en),
  .cfg_loopback  (cfg_loopback),
  .cfg_fifo_en   (cfg_fifo_en),
  .rx_data_avail (rx_data_avail),
  .bit_tick      (bit_tick),
  .irq_tx        (irq_tx),
  .irq_rx        (irq_rx),
  .irq_err       (irq_err),
  .brk_active    (brk_active),
  .pin_txd       (pin_txd)
);

// File: tb/uart_irq_line_ctl_tb_top.sv
module uart_irq_line_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tx_level = 0, cfg_rx_level = 0, cfg_timeout_en = 0, cfg_err_en = 0;
  logic cfg_loopback = 0, cfg_fifo_en = 0, cfg_parity_en = 0, cfg_two_stop = 0;
  logic [1:0] cfg_data_bits = 2'd0;
  logic brk_set = 0, bit_tick = 0;
  logic tx_empty = 0, tx_fifo_trig = 0, rx_data_avail = 0, rx_fifo_trig = 0, rx_timeout = 0;
  logic [3:0] rx_err = 4'd0;
  logic ser_tx = 1'b1, pin_rxd = 1'b1;
  logic irq_tx, irq_rx, irq_err, brk_active, pin_txd, core_rxd;

  always #5 clk = ~clk;

  uart_irq_line_ctl dut_i (
    .clk(clk), .rst(rst),
    .cfg_tx_level(cfg_tx_level), .cfg_rx_level(cfg_rx_level),
    .cfg_timeout_en(cfg_timeout_en), .cfg_err_en(cfg_err_en),
    .cfg_loopback(cfg_loopback), .cfg_fifo_en(cfg_fifo_en),
    .cfg_parity_en(cfg_parity_en), .cfg_two_stop(cfg_two_stop),
    .cfg_data_bits(cfg_data_bits), .brk_set(brk_set), .bit_tick(bit_tick),
    .tx_empty(tx_empty), .tx_fifo_trig(tx_fifo_trig),
    .rx_data_avail(rx_data_avail), .rx_fifo_trig(rx_fifo_trig),
    .rx_timeout(rx_timeout), .rx_err(rx_err),
    .ser_tx(ser_tx), .pin_rxd(pin_rxd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .brk_active(brk_active), .pin_txd(pin_txd), .core_rxd(core_rxd)
  );

  // Output vector order: {irq_tx, irq_rx, irq_err, brk_active, pin_txd, core_rxd}
  typedef struct {
    logic [5:0] exp;
    logic [5:0] care;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [5:0] M_TX  = 6'b100000;
  localparam logic [5:0] M_RX  = 6'b010000;
  localparam logic [5:0] M_ERR = 6'b001000;
  localparam logic [5:0] M_BRK = 6'b000100;
  localparam logic [5:0] M_PIN = 6'b000010;
  localparam logic [5:0] M_CORE = 6'b000001;

  task automatic step(input logic [5:0] e, input logic [5:0] m, input string tag);
    exp_item_t it;
    it.exp = e; it.care = m; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      logic [5:0] got;
      it  = sb_q.pop_front();
      got = {irq_tx, irq_rx, irq_err, brk_active, pin_txd, core_rxd};
      n_chk++;
      if (((got ^ it.exp) & it.care) != 6'd0) begin
        n_fail++;
        $display("FAIL %s got=%b exp=%b care=%b", it.tag, got, it.exp, it.care);
      end
    end
  end

  task automatic run_break(input int len, input bit loop, input bit tick_at_set,
                           input bit reissue, input string tag);
    logic [5:0] e;
    brk_set = 1'b1;
    bit_tick = tick_at_set;
    step(6'b000100, M_BRK, tag);
    brk_set = 1'b0;
    bit_tick = 1'b0;
    e = {3'b000, 1'b1, loop ? 1'b1 : 1'b0, loop ? 1'b0 : 1'b1};
    step(e, M_BRK | M_PIN | (loop ? M_CORE : 6'd0), tag);
    for (int i = 1; i <= len; i++) begin
      bit_tick = 1'b1;
      brk_set  = (reissue && i == 2);
      step({3'b000, (i < len), 2'b00}, M_BRK, tag);
      bit_tick = 1'b0;
      brk_set  = 1'b0;
      if (loop)
        step({3'b000, (i < len), 1'b1, ~(i < len)}, M_BRK | M_PIN | M_CORE, tag);
      else
        step({3'b000, (i < len), ~(i < len), 1'b0}, M_BRK | M_PIN, tag);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values
    rst = 1'b1; tx_empty = 1'b1; rx_err = 4'hF; cfg_err_en = 1'b1;
    step(6'b000011, 6'b111111, "R1");
    step(6'b000011, 6'b111111, "R1");
    tx_empty = 1'b0; rx_err = 4'h0; cfg_err_en = 1'b0;
    rst = 1'b0;
    step(6'b000011, 6'b111111, "R1");

    // R2: transmit pulse style
    tx_empty = 1'b1; step(6'b100000, M_TX, "R2");
    step(6'b000000, M_TX, "R2");
    step(6'b000000, M_TX, "R2");
    tx_empty = 1'b0; step(6'b000000, M_TX, "R2");
    tx_empty = 1'b1; step(6'b100000, M_TX, "R2");
    tx_empty = 1'b0; step(6'b000000, M_TX, "R2");

    // R3: transmit level style
    cfg_tx_level = 1'b1;
    tx_empty = 1'b1; step(6'b100000, M_TX, "R3");
    step(6'b100000, M_TX, "R3");
    tx_empty = 1'b0; step(6'b000000, M_TX, "R3");

    // R4: condition selection by FIFO mode
    cfg_fifo_en = 1'b1; tx_empty = 1'b1;
    step(6'b000000, M_TX, "R4");
    tx_fifo_trig = 1'b1; step(6'b100000, M_TX, "R4");
    tx_empty = 1'b0; step(6'b100000, M_TX, "R4");
    tx_fifo_trig = 1'b0;
    cfg_rx_level = 1'b1; rx_data_avail = 1'b1;
    step(6'b000000, M_TX | M_RX, "R4");
    rx_fifo_trig = 1'b1; step(6'b010000, M_RX, "R4");
    rx_fifo_trig = 1'b0; rx_data_avail = 1'b0; cfg_fifo_en = 1'b0;
    step(6'b000000, M_RX, "R4");

    // R5: receive pulse and level
    cfg_rx_level = 1'b0;
    rx_data_avail = 1'b1; step(6'b010000, M_RX, "R5");
    step(6'b000000, M_RX, "R5");
    rx_data_avail = 1'b0; step(6'b000000, M_RX, "R5");
    cfg_rx_level = 1'b1;
    rx_data_avail = 1'b1; step(6'b010000, M_RX, "R5");
    step(6'b010000, M_RX, "R5");
    rx_data_avail = 1'b0; step(6'b000000, M_RX, "R5");

    // R6: timeout gating
    cfg_fifo_en = 1'b1; rx_timeout = 1'b1;
    step(6'b000000, M_RX, "R6");
    cfg_timeout_en = 1'b1; step(6'b010000, M_RX, "R6");
    cfg_fifo_en = 1'b0; step(6'b000000, M_RX, "R6");
    rx_timeout = 1'b0; cfg_timeout_en = 1'b0;
    step(6'b000000, M_RX, "R6");

    // R7: error requests
    for (int b = 0; b < 4; b++) begin
      rx_err = 4'(1 << b); step(6'b000000, M_ERR, "R7");
      rx_err = 4'h0;       step(6'b000000, M_ERR, "R7");
    end
    cfg_err_en = 1'b1;
    for (int b = 0; b < 4; b++) begin
      rx_err = 4'(1 << b); step(6'b001000, M_ERR, "R7");
      rx_err = 4'h0;       step(6'b000000, M_ERR, "R7");
    end
    cfg_err_en = 1'b0;

    // R8 / R9: break frame lengths
    cfg_data_bits = 2'd0; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
    run_break(7, 1'b0, 1'b0, 1'b1, "R8_R9_len7_reissue");
    cfg_data_bits = 2'd3; cfg_parity_en = 1'b1; cfg_two_stop = 1'b1;
    run_break(12, 1'b0, 1'b0, 1'b0, "R9_len12");
    cfg_data_bits = 2'd2; cfg_parity_en = 1'b1; cfg_two_stop = 1'b0;
    run_break(10, 1'b0, 1'b1, 1'b0, "R8_R9_len10_tick_at_set");

    // R10: loopback routing
    cfg_loopback = 1'b1; ser_tx = 1'b0; pin_rxd = 1'b1;
    step(6'b000010, M_PIN | M_CORE, "R10");
    ser_tx = 1'b1; pin_rxd = 1'b0;
    step(6'b000011, M_PIN | M_CORE, "R10");
    cfg_loopback = 1'b0;
    step(6'b000010, M_PIN | M_CORE, "R10");
    ser_tx = 1'b0; pin_rxd = 1'b1;
    step(6'b000001, M_PIN | M_CORE, "R10");
    ser_tx = 1'b1;

    // R11: break inside loopback
    cfg_loopback = 1'b1;
    cfg_data_bits = 2'd0; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
    run_break(7, 1'b1, 1'b0, 1'b0, "R11");
    cfg_loopback = 1'b0;
    step(6'b000011, M_BRK | M_PIN | M_CORE, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule